// File: doc/BRIEF.md
# Descriptor DMA Process Status Controller

This block holds the run state of the two processes of a descriptor-ring DMA engine, one for transmit and one for receive. Each process is Stopped, Running or Suspended. Start and stop commands move a process in and out of Stopped. Descriptor fetch results and frame events move it between Running and Suspended. Poll demands and frame arrival bring a suspended process back. The block also keeps a nine-bit register of sticky event flags. The host clears a flag by writing 1 to it.

A fetch-enable output per process tells the descriptor fetcher when it may read the next descriptor. Both processes come out of reset in Stopped, with every flag clear. All inputs are sampled on the rising clock edge, and the state, flags and fetch enables change on that same edge.

State encoding on `tx_state` and `rx_state`: 0 = Stopped, 1 = Running, 2 = Suspended. The names of the transitions are:
- START (Stopped to Running).
- HALT (any state to Stopped, on a stop command).
- ABORT (transmit Running to Stopped, on jabber timeout).
- STARVE (Running to Suspended, on a host-owned descriptor).
- UNDERRUN (transmit Running to Suspended).
- POLL (Suspended to Running).
- ARRIVE (receive Suspended to Running).

Top module: `dma_proc_status`

## Requirements
- R1: After reset both states are 0 (Stopped), `sts` is 0 and both fetch enables are low.
- R2: A start command in Stopped gives Running on the next cycle. A fetch enable is high exactly while its process is Running. A stop command in Running or Suspended gives Stopped, and it sets `sts[1]` for transmit or `sts[8]` for receive.
- R3: A transmit completion in Running sets `sts[0]` and leaves transmit in Running.
- R4: A transmit fetch result with the owner bit at 0 (host) in Running gives Suspended and sets `sts[2]`. An owner bit of 1 (DMA) changes nothing.
- R5: A transmit underflow in Running gives Suspended and sets `sts[5]`.
- R6: A jabber timeout in Running gives Stopped and sets both `sts[3]` and `sts[1]`.
- R7: Suspended transmit stays Suspended until a transmit poll demand, which gives Running.
- R8: In receive Running, a completion sets `sts[6]` and an overflow sets `sts[4]`, and receive stays Running.
- R9: A receive fetch result with the owner bit at 0 in Running gives Suspended. It sets `sts[7]` only if the previously fetched receive descriptor was DMA-owned. The first fetch after a start counts as following a DMA-owned one.
- R10: Suspended receive gives Running on a receive poll demand or on a frame arrival.
- R11: `sts` bits are sticky until `sts_clr` has a 1 in that position. An event in the same cycle as the clear leaves the bit set.
- R12: A poll demand in Running or Stopped, and a frame arrival in Running, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Transmit start command |
| tx_stop | input | 1 | Transmit stop command |
| tx_desc_vld | input | 1 | Transmit descriptor fetch result valid |
| tx_desc_dma | input | 1 | Owner bit of that descriptor, 1 = DMA |
| tx_done | input | 1 | Transmit frame finished |
| tx_underflow | input | 1 | Transmit buffer underflow |
| tx_jabber | input | 1 | Transmit jabber timer expired |
| tx_poll | input | 1 | Transmit poll demand |
| rx_start | input | 1 | Receive start command |
| rx_stop | input | 1 | Receive stop command |
| rx_desc_vld | input | 1 | Receive descriptor fetch result valid |
| rx_desc_dma | input | 1 | Owner bit of that descriptor, 1 = DMA |
| rx_done | input | 1 | Receive frame finished |
| rx_overflow | input | 1 | Receive buffer overflow |
| rx_poll | input | 1 | Receive poll demand |
| rx_arrive | input | 1 | Recognized incoming frame arrived |
| sts_clr | input | 9 | Write-1-to-clear strobe, one bit per flag |
| sts | output | 9 | Sticky status flags |
| tx_state | output | 2 | Transmit process state |
| rx_state | output | 2 | Receive process state |
| tx_fetch_en | output | 1 | Transmit descriptor fetch allowed |
| rx_fetch_en | output | 1 | Receive descriptor fetch allowed |

## Verification
The assertions take the events in the forms that the datapath produces them. Fetch results, completions, underflow, overflow and jabber pulses arrive only while their process is Running. The owner bit is meaningful only with its valid strobe. The stimulus keeps to these forms: each event vector is applied only after the table has brought the matching process into Running. The one exception is the poll and arrival strobes, which are given in every state on purpose, because their behaviour in each state is the thing under check.

// File: rtl/dps_pkg.sv
package dps_pkg;
    localparam int STS_W = 9;

    // flag positions
    localparam int B_TDONE = 0;
    localparam int B_TSTOP = 1;
    localparam int B_TBU   = 2;
    localparam int B_TJAB  = 3;
    localparam int B_ROVF  = 4;
    localparam int B_TUNF  = 5;
    localparam int B_RDONE = 6;
    localparam int B_RBU   = 7;
    localparam int B_RSTOP = 8;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_SUSP = 2'd2
    } proc_state_e;
endpackage

// File: rtl/dps_tx_fsm.sv
module dps_tx_fsm
    import dps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic        desc_vld_i,
    input  logic        desc_dma_i,
    input  logic        done_i,
    input  logic        unf_i,
    input  logic        jab_i,
    input  logic        poll_i,
    output proc_state_e state_o,
    output logic        fetch_en_o,
    output logic        set_done_o,
    output logic        set_stop_o,
    output logic        set_bu_o,
    output logic        set_jab_o,
    output logic        set_unf_o
);
    proc_state_e state_q, state_d;
    logic        running;

    assign running = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // next state: stop > jabber > underflow > host-owned descriptor
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (!stop_i && start_i) state_d = ST_RUN;
            ST_RUN: begin
                if (stop_i || jab_i)                    state_d = ST_STOP;
                else if (unf_i)                         state_d = ST_SUSP;
                else if (desc_vld_i && !desc_dma_i)     state_d = ST_SUSP;
            end
            ST_SUSP: begin
                if (stop_i)      state_d = ST_STOP;
                else if (poll_i) state_d = ST_RUN;
            end
            default: state_d = ST_STOP;
        endcase
    end

    // outputs and flag set strobes
    always_comb begin
        fetch_en_o = running;
        set_done_o = running && done_i;
        set_jab_o  = running && !stop_i && jab_i;
        set_unf_o  = running && !stop_i && !jab_i && unf_i;
        set_bu_o   = running && !stop_i && !jab_i && !unf_i && desc_vld_i && !desc_dma_i;
        set_stop_o = (state_q != ST_STOP) && (state_d == ST_STOP);
    end

    assign state_o = state_q;
endmodule

// File: rtl/dps_rx_fsm.sv
module dps_rx_fsm
    import dps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic        desc_vld_i,
    input  logic        desc_dma_i,
    input  logic        done_i,
    input  logic        ovf_i,
    input  logic        poll_i,
    input  logic        arrive_i,
    output proc_state_e state_o,
    output logic        fetch_en_o,
    output logic        set_done_o,
    output logic        set_ovf_o,
    output logic        set_bu_o,
    output logic        set_stop_o
);
    proc_state_e state_q, state_d;
    logic        prev_dma_q;   // previous fetched descriptor was DMA-owned
    logic        running;
    logic        starve;

    assign running = (state_q == ST_RUN);
    assign starve  = running && !stop_i && desc_vld_i && !desc_dma_i;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          prev_dma_q <= 1'b1;
        else if (state_q == ST_STOP && start_i) prev_dma_q <= 1'b1;
        else if (running && desc_vld_i)      prev_dma_q <= desc_dma_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (!stop_i && start_i) state_d = ST_RUN;
            ST_RUN: begin
                if (stop_i)      state_d = ST_STOP;
                else if (starve) state_d = ST_SUSP;
            end
            ST_SUSP: begin
                if (stop_i)                  state_d = ST_STOP;
                else if (poll_i || arrive_i) state_d = ST_RUN;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_comb begin
        fetch_en_o = running;
        set_done_o = running && done_i;
        set_ovf_o  = running && ovf_i;
        set_bu_o   = starve && prev_dma_q;
        set_stop_o = (state_q != ST_STOP) && (state_d == ST_STOP);
    end

    assign state_o = state_q;
endmodule

// File: rtl/dps_flags.sv
module dps_flags
    import dps_pkg::*;
#(
    parameter int W = STS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
        end
        assign flags_o[i] = q;
    end
endmodule

// File: rtl/dma_proc_status.sv
module dma_proc_status
    import dps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start,
    input  logic             tx_stop,
    input  logic             tx_desc_vld,
    input  logic             tx_desc_dma,
    input  logic             tx_done,
    input  logic             tx_underflow,
    input  logic             tx_jabber,
    input  logic             tx_poll,
    input  logic             rx_start,
    input  logic             rx_stop,
    input  logic             rx_desc_vld,
    input  logic             rx_desc_dma,
    input  logic             rx_done,
    input  logic             rx_overflow,
    input  logic             rx_poll,
    input  logic             rx_arrive,
    input  logic [STS_W-1:0] sts_clr,
    output logic [STS_W-1:0] sts,
    output logic [1:0]       tx_state,
    output logic [1:0]       rx_state,
    output logic             tx_fetch_en,
    output logic             rx_fetch_en
);
    proc_state_e      tx_st, rx_st;
    logic             t_done, t_stop, t_bu, t_jab, t_unf;
    logic             r_done, r_ovf, r_bu, r_stop;
    logic [STS_W-1:0] set_vec;

    dps_tx_fsm u_tx (
        .clk(clk), .rst_n(rst_n),
        .start_i(tx_start), .stop_i(tx_stop),
        .desc_vld_i(tx_desc_vld), .desc_dma_i(tx_desc_dma),
        .done_i(tx_done), .unf_i(tx_underflow), .jab_i(tx_jabber),
        .poll_i(tx_poll),
        .state_o(tx_st), .fetch_en_o(tx_fetch_en),
        .set_done_o(t_done), .set_stop_o(t_stop), .set_bu_o(t_bu),
        .set_jab_o(t_jab), .set_unf_o(t_unf)
    );

    dps_rx_fsm u_rx (
        .clk(clk), .rst_n(rst_n),
        .start_i(rx_start), .stop_i(rx_stop),
        .desc_vld_i(rx_desc_vld), .desc_dma_i(rx_desc_dma),
        .done_i(rx_done), .ovf_i(rx_overflow),
        .poll_i(rx_poll), .arrive_i(rx_arrive),
        .state_o(rx_st), .fetch_en_o(rx_fetch_en),
        .set_done_o(r_done), .set_ovf_o(r_ovf),
        .set_bu_o(r_bu), .set_stop_o(r_stop)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[B_TDONE] = t_done;
        set_vec[B_TSTOP] = t_stop;
        set_vec[B_TBU]   = t_bu;
        set_vec[B_TJAB]  = t_jab;
        set_vec[B_ROVF]  = r_ovf;
        set_vec[B_TUNF]  = t_unf;
        set_vec[B_RDONE] = r_done;
        set_vec[B_RBU]   = r_bu;
        set_vec[B_RSTOP] = r_stop;
    end

    dps_flags #(.W(STS_W)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_i(set_vec), .clr_i(sts_clr), .flags_o(sts)
    );

    assign tx_state = tx_st;
    assign rx_state = rx_st;
endmodule

// File: rtl/dps_checker.sv
module dps_checker
    import dps_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tx_start,
    input logic             tx_stop,
    input logic             tx_jabber,
    input logic             tx_poll,
    input logic             rx_stop,
    input logic             rx_arrive,
    input logic [STS_W-1:0] sts_clr,
    input logic [STS_W-1:0] sts,
    input logic [1:0]       tx_state,
    input logic [1:0]       rx_state,
    input logic             tx_fetch_en
);
    // R6
    tx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_state == ST_RUN && tx_jabber && !tx_stop)
        |=> (tx_state == ST_STOP && sts[B_TJAB] && sts[B_TSTOP]));

    // R10
    rx_arrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == ST_SUSP && rx_arrive && !rx_stop) |=> (rx_state == ST_RUN));

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sts) & ~$past(sts_clr)) & ~sts) == '0));

    // R2
    fetch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_fetch_en) |-> ($past(tx_start) || $past(tx_poll)));

    // R9
    rbu_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == ST_SUSP) |=> !$rose(sts[B_RBU]));

    // R2
    halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state != ST_STOP && rx_stop) |=> (rx_state == ST_STOP && sts[B_RSTOP]));
endmodule

bind dma_proc_status dps_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_start(tx_start), .tx_stop(tx_stop), .tx_jabber(tx_jabber), .tx_poll(tx_poll),
    .rx_stop(rx_stop), .rx_arrive(rx_arrive),
    .sts_clr(sts_clr), .sts(sts),
    .tx_state(tx_state), .rx_state(rx_state), .tx_fetch_en(tx_fetch_en)
);

// File: tb/dma_proc_status_test.sv
module dma_proc_status_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;

    typedef struct packed {
        logic [7:0] tx;   // start,stop,dvld,dma,done,unf,jab,poll
        logic [7:0] rx;   // start,stop,dvld,dma,done,ovf,poll,arrive
        logic [8:0] clr;
        logic [8:0] sts;
        logic [1:0] ts;
        logic [1:0] rs;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'h02, 9'h000, 9'h000, 2'd0, 2'd0, 4'd12}, // R12 poll in Stopped
        '{8'h80, 8'h80, 9'h000, 9'h000, 2'd1, 2'd1, 4'd2 }, // R2 start
        '{8'h08, 8'h08, 9'h000, 9'h041, 2'd1, 2'd1, 4'd3 }, // R3 tx done, R8 rx done
        '{8'h01, 8'h04, 9'h000, 9'h051, 2'd1, 2'd1, 4'd8 }, // R8 overflow, R12 poll in Running
        '{8'h00, 8'h00, 9'h051, 9'h000, 2'd1, 2'd1, 4'd11}, // R11 clear
        '{8'h30, 8'h30, 9'h000, 9'h000, 2'd1, 2'd1, 4'd4 }, // R4 DMA-owned: no change
        '{8'h20, 8'h00, 9'h000, 9'h004, 2'd2, 2'd1, 4'd4 }, // R4 host-owned
        '{8'h00, 8'h01, 9'h000, 9'h004, 2'd2, 2'd1, 4'd7 }, // R7 stays, R12 arrive in Running
        '{8'h01, 8'h00, 9'h000, 9'h004, 2'd1, 2'd1, 4'd7 }, // R7 poll resumes
        '{8'h00, 8'h20, 9'h000, 9'h084, 2'd1, 2'd2, 4'd9 }, // R9 first starve
        '{8'h00, 8'h00, 9'h084, 9'h000, 2'd1, 2'd2, 4'd11}, // R11
        '{8'h00, 8'h01, 9'h000, 9'h000, 2'd1, 2'd1, 4'd10}, // R10 arrive
        '{8'h00, 8'h20, 9'h000, 9'h000, 2'd1, 2'd2, 4'd9 }, // R9 repeat: no flag
        '{8'h00, 8'h02, 9'h000, 9'h000, 2'd1, 2'd1, 4'd10}, // R10 poll
        '{8'h00, 8'h30, 9'h000, 9'h000, 2'd1, 2'd1, 4'd9 }, // R9 DMA-owned
        '{8'h00, 8'h20, 9'h000, 9'h080, 2'd1, 2'd2, 4'd9 }, // R9 flag again
        '{8'h00, 8'h40, 9'h000, 9'h180, 2'd1, 2'd0, 4'd2 }, // R2 rx halt
        '{8'h04, 8'h00, 9'h000, 9'h1A0, 2'd2, 2'd0, 4'd5 }, // R5 underflow
        '{8'h01, 8'h00, 9'h000, 9'h1A0, 2'd1, 2'd0, 4'd7 }, // R7
        '{8'h02, 8'h00, 9'h100, 9'h0AA, 2'd0, 2'd0, 4'd6 }, // R6 jabber
        '{8'h80, 8'h80, 9'h000, 9'h0AA, 2'd1, 2'd1, 4'd2 }, // R2
        '{8'h40, 8'h00, 9'h002, 9'h0AA, 2'd0, 2'd1, 4'd11}, // R11 event wins
        '{8'h00, 8'h20, 9'h000, 9'h0AA, 2'd0, 2'd2, 4'd9 }, // R9 after restart
        '{8'h00, 8'h00, 9'h1FF, 9'h000, 2'd0, 2'd2, 4'd11}, // R11 clear all
        '{8'h00, 8'h40, 9'h000, 9'h100, 2'd0, 2'd0, 4'd2 }  // R2 halt from Suspended
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] txi = '0;
    logic [7:0] rxi = '0;
    logic [8:0] sts_clr = '0;
    logic [8:0] sts;
    logic [1:0] tx_state, rx_state;
    logic tx_fetch_en, rx_fetch_en;
    int checks = 0;
    int fails = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_proc_status uut (
        .clk(clk), .rst_n(rst_n),
        .tx_start(txi[7]), .tx_stop(txi[6]), .tx_desc_vld(txi[5]), .tx_desc_dma(txi[4]),
        .tx_done(txi[3]), .tx_underflow(txi[2]), .tx_jabber(txi[1]), .tx_poll(txi[0]),
        .rx_start(rxi[7]), .rx_stop(rxi[6]), .rx_desc_vld(rxi[5]), .rx_desc_dma(rxi[4]),
        .rx_done(rxi[3]), .rx_overflow(rxi[2]), .rx_poll(rxi[1]), .rx_arrive(rxi[0]),
        .sts_clr(sts_clr), .sts(sts),
        .tx_state(tx_state), .rx_state(rx_state),
        .tx_fetch_en(tx_fetch_en), .rx_fetch_en(rx_fetch_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [8:0] es,
                             input logic [1:0] et, input logic [1:0] er);
        check({tag, " sts"}, 32'(sts), 32'(es));
        check({tag, " tx_state"}, 32'(tx_state), 32'(et));
        check({tag, " rx_state"}, 32'(rx_state), 32'(er));
        check({tag, " tx_fetch_en"}, 32'(tx_fetch_en), 32'(et == 2'd1));
        check({tag, " rx_fetch_en"}, 32'(rx_fetch_en), 32'(er == 2'd1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all("R1 in reset", 9'h000, 2'd0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset", 9'h000, 2'd0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            txi = VECS[i].tx;
            rxi = VECS[i].rx;
            sts_clr = VECS[i].clr;
            @(negedge clk);
            txi = '0; rxi = '0; sts_clr = '0;
            check_all($sformatf("R%0d vec %0d", VECS[i].req, i),
                      VECS[i].sts, VECS[i].ts, VECS[i].rs);
        end

        // R12: poll with tx Stopped changes nothing; R2 start then mid-run reset gives R1
        txi = 8'h01;
        @(negedge clk);
        txi = '0;
        check_all("R12 tx poll stopped", 9'h100, 2'd0, 2'd0);
        txi = 8'h80; rxi = 8'h80;
        @(negedge clk);
        txi = 8'h08; rxi = '0;
        @(negedge clk);
        txi = '0;
        check_all("R3 done after start", 9'h101, 2'd1, 2'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 mid-run reset", 9'h000, 2'd0, 2'd0);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule